// File: doc/BRIEF.md
# Fixed-Slot Round-Robin Memory Hub

The hub shares one word-wide main memory among eight requesters by time slicing. A free-running slot counter turns over every sixteen system clocks. Each requester owns two consecutive clocks of that rotation, and the requester index is the upper three bits of the counter. The rotation never looks at who is asking. A requester that is idle still uses up its slot, so the worst-case wait and the best-case throughput are both fixed numbers.

A requester presents a valid flag, a read/write flag, a size, a byte address and write data. When its slot opens and its valid flag is high, the hub performs exactly one access for it, either a read or a write, and pulses that requester's done bit in the second clock of the slot. Reads return zero-extended data on a shared response bus. A requester that misses the opening clock of its slot waits a full rotation. A requester that keeps its valid flag high is served once per rotation.

Top module: `slot_hub`

## Requirements
- R1: While rst_n is low at a clock edge, the slot counter returns to zero, so slot_owner reads 0, every rsp_done bit reads 0 and rsp_data reads 0 after that edge.
- R2: Out of reset the slot counter advances by one on every clock and wraps from 15 to 0 whatever the request inputs do. slot_owner equals counter bits [3:1], so each requester owns two consecutive clocks and the order is 0, 1, ..., 7.
- R3: A request is taken only at the clock edge that ends the first clock of its owner's slot (counter even) while that owner's req_valid is high. The matching rsp_done bit is then high for exactly the following clock, which is the second clock of the same slot, and no other done bit is high.
- R4: req_valid from a requester that does not own the current opening clock has no effect: no done pulse is produced and memory contents are unchanged.
- R5: A request raised during the second clock of its own slot is not served in that slot. It is served in the next rotation, and its done pulse arrives 16 clocks after the request was first visible.
- R6: Writes use req_size 0 = byte, 1 = 16-bit half, 2 = 32-bit long (3 acts as long). Memory is little-endian in 32-bit words. A byte write changes only the lane at address bits [1:0], a half write only the half at address bit 1, and a long write the whole word. Lower address bits that fall below the access size are ignored.
- R7: A read returns the selected byte, half or long zero-extended to 32 bits on rsp_data in the done clock. rsp_data is 0 in every clock without a read done, including write completions.
- R8: Each slot performs at most one access, and at most one rsp_done bit is high in any clock.
- R9: A requester holding req_valid high continuously is served exactly once per 16 clocks, which gives four done pulses in any 64 consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 8 | Per-requester request flag |
| req_write | input | 8 | Per-requester direction, 1 = write |
| req_size | input | 16 | Two bits per requester: 0 byte, 1 half, 2 long |
| req_addr | input | 80 | Ten-bit byte address per requester |
| req_wdata | input | 256 | 32-bit write data per requester, low lanes used for narrow writes |
| rsp_done | output | 8 | One-clock completion pulse per requester |
| rsp_data | output | 32 | Zero-extended read data, valid with a read done |
| slot_owner | output | 3 | Requester owning the current slot |

## Verification
The assertions assume a clean synchronous reset at start-up. They also assume the request inputs change only between clock edges, so the sample taken at the opening edge is well defined. They assume nothing about how often or how long requesters ask. The bench drives all inputs on the falling edge. It reads back only locations it has first filled with a write pass, which keeps the never-written memory contents out of every comparison. Its random phase raises valid flags at arbitrary phases of the rotation to exercise late and foreign-slot requests.

// File: rtl/hub_pkg.sv
// Shared types and lane helpers for the slot hub.
// Assumes a 32-bit little-endian memory word.
package hub_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_LONG = 2'd2,
        SZ_ALT  = 2'd3
    } acc_size_t;

    // Byte-enable mask for an access of the given size at a word offset.
    function automatic logic [3:0] lane_mask(acc_size_t sz, logic [1:0] off);
        case (sz)
            SZ_BYTE: lane_mask = 4'b0001 << off;
            SZ_HALF: lane_mask = off[1] ? 4'b1100 : 4'b0011;
            default: lane_mask = 4'b1111;
        endcase
    endfunction

    // Replicate narrow write data across all lanes it may land in.
    function automatic logic [31:0] lane_spread(acc_size_t sz, logic [31:0] d);
        case (sz)
            SZ_BYTE: lane_spread = {4{d[7:0]}};
            SZ_HALF: lane_spread = {2{d[15:0]}};
            default: lane_spread = d;
        endcase
    endfunction

    // Extract and zero-extend the addressed field of a word.
    function automatic logic [31:0] lane_pick(acc_size_t sz, logic [1:0] off, logic [31:0] w);
        logic [31:0] sh;
        sh = w >> {off, 3'b000};
        case (sz)
            SZ_BYTE: lane_pick = {24'd0, sh[7:0]};
            SZ_HALF: lane_pick = off[1] ? {16'd0, w[31:16]} : {16'd0, w[15:0]};
            default: lane_pick = w;
        endcase
    endfunction

endpackage

// File: rtl/hub_slot_timer.sv
// Free-running slot counter. It names the requester that owns the current
// slot and flags the opening clock of each slot.
// Assumes CLKS_PER_SLOT and NUM_REQ are powers of two, with CLKS_PER_SLOT >= 2.
module hub_slot_timer #(
    parameter int NUM_REQ       = 8,
    parameter int CLKS_PER_SLOT = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    output logic [$clog2(NUM_REQ)-1:0] owner,
    output logic                       open
);
    localparam int OWN_W = $clog2(NUM_REQ);
    localparam int PH_W  = $clog2(CLKS_PER_SLOT);
    localparam int CNT_W = OWN_W + PH_W;

    logic [CNT_W-1:0] cnt;

    // Advance one step per clock; the counter ignores all request activity.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt + 1'b1;
    end

    assign owner = cnt[CNT_W-1:PH_W];
    assign open  = (cnt[PH_W-1:0] == '0);

    // R2: the count moves by exactly one on every clock after reset
    a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> cnt == CNT_W'($past(cnt) + 1'b1));

    // R2: the owner changes only when a new slot opens
    a_r2_owner_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !open) |-> $stable(owner));

endmodule

// File: rtl/hub_req_select.sv
// Picks the owner's request fields out of the flat request buses and raises
// fire when the owner asks during the opening clock of its slot.
// Assumes inputs are stable around the clock edge.
module hub_req_select
    import hub_pkg::*;
#(
    parameter int NUM_REQ = 8,
    parameter int ADDR_W  = 10,
    parameter int DATA_W  = 32
) (
    input  logic [NUM_REQ-1:0]         req_valid,
    input  logic [NUM_REQ-1:0]         req_write,
    input  logic [2*NUM_REQ-1:0]       req_size,
    input  logic [NUM_REQ*ADDR_W-1:0]  req_addr,
    input  logic [NUM_REQ*DATA_W-1:0]  req_wdata,
    input  logic [$clog2(NUM_REQ)-1:0] owner,
    input  logic                       open,
    output logic                       fire,
    output logic                       sel_write,
    output acc_size_t                  sel_size,
    output logic [ADDR_W-1:0]          sel_addr,
    output logic [DATA_W-1:0]          sel_wdata
);
    logic [1:0]        size_a  [NUM_REQ];
    logic [ADDR_W-1:0] addr_a  [NUM_REQ];
    logic [DATA_W-1:0] wdata_a [NUM_REQ];

    // Unpack each requester's fields from the flat buses.
    for (genvar i = 0; i < NUM_REQ; i++) begin : g_unpack
        assign size_a[i]  = req_size[2*i +: 2];
        assign addr_a[i]  = req_addr[i*ADDR_W +: ADDR_W];
        assign wdata_a[i] = req_wdata[i*DATA_W +: DATA_W];
    end

    // Route only the slot owner's request toward the memory.
    always_comb begin
        fire      = open & req_valid[owner];
        sel_write = req_write[owner];
        sel_size  = acc_size_t'(size_a[owner]);
        sel_addr  = addr_a[owner];
        sel_wdata = wdata_a[owner];
    end

endmodule

// File: rtl/hub_mem.sv
// Shared main memory with byte lanes and a one-clock registered read.
// Assumes at most one access per clock; unwritten words read as unknown.
module hub_mem
    import hub_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en,
    input  logic              acc_write,
    input  acc_size_t         acc_size,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [31:0]       acc_wdata,
    output logic [31:0]       rdata
);
    localparam int WORDS = 2 ** (ADDR_W - 2);

    logic [31:0]       mem [WORDS];
    logic [ADDR_W-3:0] idx;
    logic [3:0]        be;
    logic [31:0]       wl;
    logic              rd_vld_q;
    acc_size_t         size_q;
    logic [1:0]        off_q;
    logic [31:0]       word_q;

    assign idx = acc_addr[ADDR_W-1:2];
    assign be  = lane_mask(acc_size, acc_addr[1:0]);
    assign wl  = lane_spread(acc_size, acc_wdata);

    // Write the enabled byte lanes of the addressed word.
    always_ff @(posedge clk) begin
        if (acc_en && acc_write) begin
            for (int b = 0; b < 4; b++) begin
                if (be[b]) mem[idx][8*b +: 8] <= wl[8*b +: 8];
            end
        end
    end

    // Capture the read word and its lane selection for the next clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_vld_q <= 1'b0;
            size_q   <= SZ_LONG;
            off_q    <= 2'd0;
            word_q   <= '0;
        end else begin
            rd_vld_q <= acc_en && !acc_write;
            if (acc_en && !acc_write) begin
                size_q <= acc_size;
                off_q  <= acc_addr[1:0];
                word_q <= mem[idx];
            end
        end
    end

    assign rdata = rd_vld_q ? lane_pick(size_q, off_q, word_q) : 32'd0;

    // R7: a byte read never drives the upper 24 bits
    a_r7_byte_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_vld_q && size_q == SZ_BYTE) |-> rdata[31:8] == 24'd0);

    // R7: the response bus is quiet whenever no read completes
    a_r7_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_vld_q |-> rdata == 32'd0);

endmodule

// File: rtl/slot_hub.sv
// Top of the fixed-slot memory hub. It ties the slot timer, the request
// selector and the memory together and pulses done to the served requester.
// Assumes CLKS_PER_SLOT >= 2, so done always falls inside the owner's slot.
module slot_hub
    import hub_pkg::*;
#(
    parameter int NUM_REQ       = 8,
    parameter int CLKS_PER_SLOT = 2,
    parameter int ADDR_W        = 10,
    parameter int DATA_W        = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_REQ-1:0]         req_valid,
    input  logic [NUM_REQ-1:0]         req_write,
    input  logic [2*NUM_REQ-1:0]       req_size,
    input  logic [NUM_REQ*ADDR_W-1:0]  req_addr,
    input  logic [NUM_REQ*DATA_W-1:0]  req_wdata,
    output logic [NUM_REQ-1:0]         rsp_done,
    output logic [DATA_W-1:0]          rsp_data,
    output logic [$clog2(NUM_REQ)-1:0] slot_owner
);
    localparam int OWN_W = $clog2(NUM_REQ);

    logic [OWN_W-1:0]  owner;
    logic              open;
    logic              fire;
    logic              sel_write;
    acc_size_t         sel_size;
    logic [ADDR_W-1:0] sel_addr;
    logic [DATA_W-1:0] sel_wdata;
    logic [NUM_REQ-1:0] done_q;

    hub_slot_timer #(.NUM_REQ(NUM_REQ), .CLKS_PER_SLOT(CLKS_PER_SLOT)) u_timer (
        .clk(clk), .rst_n(rst_n), .owner(owner), .open(open)
    );

    hub_req_select #(.NUM_REQ(NUM_REQ), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sel (
        .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
        .req_addr(req_addr), .req_wdata(req_wdata), .owner(owner), .open(open),
        .fire(fire), .sel_write(sel_write), .sel_size(sel_size),
        .sel_addr(sel_addr), .sel_wdata(sel_wdata)
    );

    hub_mem #(.ADDR_W(ADDR_W)) u_mem (
        .clk(clk), .rst_n(rst_n), .acc_en(fire), .acc_write(sel_write),
        .acc_size(sel_size), .acc_addr(sel_addr), .acc_wdata(sel_wdata),
        .rdata(rsp_data)
    );

    // Flag the served requester in the clock after its access.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= '0;
        else        done_q <= fire ? (NUM_REQ'(1) << owner) : '0;
    end

    assign rsp_done   = done_q;
    assign slot_owner = owner;

    // R8: never more than one completion at once
    a_r8_single_done: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(done_q));

    // R3: a completion only appears outside the opening clock
    a_r3_done_late_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q != '0) |-> !open);

    // R3: the done bit belongs to the requester owning the slot
    a_r3_done_owner: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q != '0) |-> done_q[owner]);

    // R3: the done pulse lasts one clock
    a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q != '0) |=> done_q == '0);

endmodule

// File: tb/slot_hub_test.sv
`timescale 1ns/1ps
// Bench for slot_hub: a behavioural model tracks the rotation and a byte
// memory and is compared with the outputs on every falling edge.
module slot_hub_test;
    localparam int N  = 8;
    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  req_valid = '0;
    logic [N-1:0]  req_write = '0;
    logic [2*N-1:0]  req_size = '0;
    logic [N*AW-1:0] req_addr = '0;
    logic [N*32-1:0] req_wdata = '0;
    logic [N-1:0]  rsp_done;
    logic [31:0]   rsp_data;
    logic [2:0]    slot_owner;

    int tests = 0;
    int fails = 0;
    bit finished = 0;
    bit live = 0;
    string tag = "R1";

    slot_hub uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_data(rsp_data), .slot_owner(slot_owner)
    );

    always #2.5 clk = ~clk;

    // Reference model state.
    logic [7:0] mm [int];
    int         m_cnt = 0;
    logic [N-1:0] e_done = '0;
    logic [31:0]  e_data = '0;

    function automatic int align(int a, int sz);
        if (sz == 0) return a;
        if (sz == 1) return a & ~1;
        return a & ~3;
    endfunction

    function automatic int nbytes(int sz);
        if (sz == 0) return 1;
        if (sz == 1) return 2;
        return 4;
    endfunction

    // Model one clock edge: rotation step, access, expected outputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; e_done = '0; e_data = '0;
        end else begin
            int o;
            o = m_cnt / 2;
            e_done = '0; e_data = '0;
            if ((m_cnt % 2) == 0 && req_valid[o]) begin
                int sz, a, n;
                logic [31:0] wd;
                sz = int'(req_size[2*o +: 2]);
                a  = align(int'(req_addr[o*AW +: AW]), sz);
                n  = nbytes(sz);
                wd = req_wdata[o*32 +: 32];
                e_done[o] = 1'b1;
                for (int b = 0; b < n; b++) begin
                    if (req_write[o]) mm[a+b] = wd[8*b +: 8];
                    else e_data[8*b +: 8] = mm[a+b];
                end
            end
            m_cnt = (m_cnt + 1) % 16;
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Per-clock comparison against the model (R2 owner, R3 done, R7 data).
    always @(negedge clk) begin
        if (live) begin
            check({tag, "/R2 owner"}, 32'(slot_owner), 32'(m_cnt / 2));
            check({tag, "/R3 done"},  32'(rsp_done), 32'(e_done));
            check({tag, "/R7 data"},  rsp_data, e_data);
        end
    end

    function automatic logic [31:0] fill(int j);
        return 32'hA500_0000 ^ (j * 32'h0001_0203);
    endfunction

    task automatic set_req(int i, bit v, bit w, int sz, int a, logic [31:0] d);
        req_valid[i] = v;
        req_write[i] = w;
        req_size[2*i +: 2] = 2'(sz);
        req_addr[i*AW +: AW] = AW'(a);
        req_wdata[i*32 +: 32] = d;
    endtask

    // One access by requester i, held until its done; returns the data.
    task automatic access(int i, bit w, int sz, int a, logic [31:0] d, output logic [31:0] q);
        @(negedge clk);
        set_req(i, 1'b1, w, sz, a, d);
        forever begin
            @(negedge clk);
            if (rsp_done[i]) begin
                q = rsp_data;
                req_valid[i] = 1'b0;
                break;
            end
        end
    endtask

    initial begin
        logic [31:0] q;
        int cnt;
        repeat (3) @(negedge clk);
        // R1: reset state after edges with rst_n low
        check("R1 owner", 32'(slot_owner), 32'd0);
        check("R1 done", 32'(rsp_done), 32'd0);
        check("R1 data", rsp_data, 32'd0);
        rst_n = 1'b1;
        live = 1;

        // R6: fill 32 longs, eight requesters per pass of 16 clocks
        tag = "R6";
        for (int r = 0; r < 4; r++) begin
            for (int i = 0; i < N; i++) set_req(i, 1'b1, 1'b1, 2, (r*8+i)*4, fill(r*8+i));
            repeat (16) @(negedge clk);
        end
        req_valid = '0;

        // R6: narrow writes land in their lanes only
        access(3, 1'b1, 0, 'h21, 32'hFFFF_FFCC, q);
        access(4, 1'b1, 1, 'h26, 32'hFFFF_BEEF, q);
        // R7: reads of each size, zero-extended
        tag = "R7";
        access(6, 1'b0, 2, 'h20, 0, q);
        check("R6 byte lane", q, 32'hA508_CC18);
        access(1, 1'b0, 0, 'h27, 0, q);
        check("R7 byte read", q, 32'h0000_00BE);
        access(0, 1'b0, 1, 'h24, 0, q);
        check("R7 half read", q, 32'h0000_121B);
        access(7, 1'b0, 2, 'h27, 0, q);
        check("R6 long ignores low bits", q, 32'hBEEF_121B);
        access(2, 1'b1, 0, 'h00, 32'h0000_0000, q);
        check("R7 write gives zero data", q, 32'd0);

        // R5: request raised in the second clock of its own slot
        tag = "R5";
        while (m_cnt != 5) @(negedge clk);
        set_req(2, 1'b1, 1'b0, 2, 'h10, 0);
        cnt = 0;
        do begin
            @(negedge clk);
            cnt++;
        end while (!rsp_done[2] && cnt < 40);
        req_valid[2] = 1'b0;
        check("R5 late request latency", 32'(cnt), 32'd16);

        // R9: continuous request gives one completion per rotation
        tag = "R9";
        @(negedge clk);
        set_req(5, 1'b1, 1'b0, 2, 'h08, 0);
        cnt = 0;
        repeat (64) begin
            @(negedge clk);
            if (rsp_done[5]) cnt++;
        end
        req_valid[5] = 1'b0;
        check("R9 four per 64 clocks", 32'(cnt), 32'd4);

        // R4/R8: random valid at arbitrary phases, foreign slots ignored
        tag = "R4";
        cnt = 0;
        for (int k = 0; k < 2000; k++) begin
            @(negedge clk);
            if ($countones(rsp_done) > 1) cnt++;
            for (int i = 0; i < N; i++)
                set_req(i, ($urandom % 4) == 0, $urandom % 2, $urandom % 3,
                        $urandom % 128, $urandom);
        end
        req_valid = '0;
        check("R8 multiple done bits", 32'(cnt), 32'd0);

        // R4: after the random phase, memory contents match the model
        for (int j = 0; j < 32; j++) begin
            logic [31:0] e;
            for (int b = 0; b < 4; b++) e[8*b +: 8] = mm[j*4+b];
            access(j % N, 1'b0, 2, j*4, 0, q);
            check("R4 memory readback", q, e);
        end

        repeat (4) @(negedge clk);
        live = 0;
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL R2 watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule